// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider Pair

This block holds the two digital dividers that set the comparison rate of a PLL frequency synthesizer. The feedback divider counts output cycles of an external 16/17 dual-modulus prescaler. It drives the modulus-control line of that prescaler so that one comparison pulse comes out for every M cycles of the oscillator. The reference divider counts reference-clock events and gives one comparison pulse for every R of them. Both dividers run in one system clock domain. The prescaler output and the reference edges arrive as one-cycle strobes.

The block stores two ratio sets, (M1, R1) and (M2, R2). One select decides which set is active. The select comes from a register bit, or from an external pin when that pin is being driven. A ratio is taken only at a period boundary, so every period is complete and built from a single ratio. The total ratio is split as M = 16·P + A, with A = M[3:0] and P = M[13:4]. During the first A prescaler cycles of each period the prescaler divides by 17, and during the remaining P − A cycles it divides by 16.

The feedback state machine has three states. FB_LOAD is entered at reset and fetches the active ratio. FB_SWALLOW holds modulus control high. FB_MAIN holds it low. Its transitions are:
- LOAD→SWALLOW when A ≠ 0, and LOAD→MAIN when A = 0.
- SWALLOW→MAIN on the prescaler strobe that uses up A.
- MAIN→SWALLOW or MAIN→MAIN (reload) on the strobe that uses up P. This reload is the period boundary.

The reference state machine has two states. RF_LOAD fetches R after reset. RF_COUNT counts strobes and reloads itself on the R-th one.

Top module: `synth_div_pair`

## Requirements
- R1: While reset is held, `fb_pulse`, `ref_pulse` and `mod_ctl` are all low.
- R2: Each feedback period takes exactly P = M[13:4] `pre_tick` strobes. `fb_pulse` is high for one clock, in the cycle after the strobe that ends the period.
- R3: `mod_ctl` is high (divide by 17) for the first A = M[3:0] prescaler cycles of each period and low for the rest. With A = 0 it stays low. It falls only after a `pre_tick`.
- R4: With a 16/17 prescaler, successive `fb_pulse` assertions are exactly M oscillator cycles apart, for M anywhere from 256 to 16383.
- R5: `ref_pulse` is high for one clock after every R-th `ref_tick`, for R anywhere from 2 to 2047, whatever the spacing of the strobes.
- R6: The effective select is `sel_pin_val` when `sel_pin_drive` is 1, and `sel_bit` otherwise. A value of 1 makes M1/R1 active and 0 makes M2/R2 active.
- R7: While `sel_pin_drive` is 1, `sel_bit` has no effect on either divider.
- R8: A change of select or a new stored ratio takes effect at the next period boundary. The period in progress completes with its old ratio.
- R9: After reset the stored values are M1 = 10519, M2 = 4269, R1 = 492 and R2 = 492.
- R10: A write with `wr_en` = 1 stores `wr_data` at `wr_addr`: 0 = M1, 1 = M2, 2 = R1, 3 = R2. An R entry keeps only `wr_data[10:0]`. An M below 256 is stored as 256, and an R below 2 is stored as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Ratio write strobe |
| wr_addr | input | 2 | Ratio entry: 0 M1, 1 M2, 2 R1, 3 R2 |
| wr_data | input | 14 | Ratio value to store |
| sel_bit | input | 1 | Register select, 1 = set 1 |
| sel_pin_drive | input | 1 | High when the select pin is being driven |
| sel_pin_val | input | 1 | Level on the select pin |
| pre_tick | input | 1 | One strobe per prescaler output cycle |
| ref_tick | input | 1 | One strobe per reference cycle |
| mod_ctl | output | 1 | Prescaler modulus: 1 = /17, 0 = /16 |
| fb_pulse | output | 1 | Feedback comparison pulse |
| ref_pulse | output | 1 | Reference comparison pulse |

## Verification
A behavioural 16/17 prescaler in the bench closes the loop and measures the pulse spacing in oscillator cycles. It also counts the prescaler cycles run at /17 and the strobes in each period. The M values used are:
- 256 and 4096, where A = 0 and the swallow phase never runs.
- 271, where A reaches its maximum over the shortest main count, so a mix-up between P and A would show.
- 16383, where both fields are at their maximum and a counter that is too narrow would wrap.
- 1000 and the reset defaults, which are mid-range mixes.

The R values 2 and 2047 are run with a strobe every cycle, and 5 is run with sparse strobes, which shows that R counts strobes rather than clocks. Select flips in the middle of a period show whether the switch waits for the boundary, and toggling the register bit while the pin is driven shows the pin override.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    typedef enum logic [1:0] {
        FB_LOAD    = 2'd0,
        FB_SWALLOW = 2'd1,
        FB_MAIN    = 2'd2
    } fb_state_t;

    typedef enum logic {
        RF_LOAD  = 1'b0,
        RF_COUNT = 1'b1
    } rf_state_t;

    localparam int NUM_SETS = 2;

endpackage

// File: rtl/div_ratio_bank.sv
module div_ratio_bank
    import synth_div_pkg::*;
#(
    parameter int M_W    = 14,
    parameter int R_W    = 11,
    parameter int M_MIN  = 256,
    parameter int R_MIN  = 2,
    parameter int M1_RST = 10519,
    parameter int M2_RST = 4269,
    parameter int R1_RST = 492,
    parameter int R2_RST = 492
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     wr_addr,
    input  logic [M_W-1:0] wr_data,
    input  logic           sel_bit,
    input  logic           sel_pin_drive,
    input  logic           sel_pin_val,
    output logic [M_W-1:0] m_act,
    output logic [R_W-1:0] r_act
);

    logic [M_W-1:0] m_store [NUM_SETS];
    logic [R_W-1:0] r_store [NUM_SETS];
    logic           sel_eff;
    logic           set_idx;
    logic [M_W-1:0] m_clamped;
    logic [R_W-1:0] r_clamped;

    always_comb begin
        m_clamped = (wr_data < M_W'(M_MIN)) ? M_W'(M_MIN) : wr_data;
        r_clamped = (wr_data[R_W-1:0] < R_W'(R_MIN)) ? R_W'(R_MIN) : wr_data[R_W-1:0];
    end

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        localparam int M_RST = (g == 0) ? M1_RST : M2_RST;
        localparam int R_RST = (g == 0) ? R1_RST : R2_RST;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                m_store[g] <= M_W'(M_RST);
                r_store[g] <= R_W'(R_RST);
            end else if (wr_en && (wr_addr[0] == 1'(g))) begin
                if (wr_addr[1]) begin
                    r_store[g] <= r_clamped;
                end else begin
                    m_store[g] <= m_clamped;
                end
            end
        end
    end

    always_comb begin
        sel_eff = sel_pin_drive ? sel_pin_val : sel_bit;
        set_idx = ~sel_eff;
        m_act   = m_store[set_idx];
        r_act   = r_store[set_idx];
    end

endmodule

// File: rtl/fb_swallow_div.sv
module fb_swallow_div
    import synth_div_pkg::*;
#(
    parameter int A_W = 4,
    parameter int P_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pre_tick,
    input  logic [A_W+P_W-1:0] m_ratio,
    output logic               mod_ctl,
    output logic               fb_pulse
);

    localparam int M_W = A_W + P_W;

    fb_state_t      st, st_nxt;
    logic [A_W-1:0] a_left, a_nxt;
    logic [P_W-1:0] p_left, p_nxt;
    logic [A_W-1:0] a_cfg;
    logic [P_W-1:0] p_cfg;
    fb_state_t      st_start;
    logic           wrap;

    always_comb begin
        a_cfg    = m_ratio[A_W-1:0];
        p_cfg    = m_ratio[M_W-1:A_W];
        st_start = (a_cfg != '0) ? FB_SWALLOW : FB_MAIN;
    end

    always_comb begin
        st_nxt = st;
        a_nxt  = a_left;
        p_nxt  = p_left;
        wrap   = 1'b0;
        unique case (st)
            FB_LOAD: begin
                a_nxt  = a_cfg;
                p_nxt  = p_cfg;
                st_nxt = st_start;
            end
            FB_SWALLOW: begin
                if (pre_tick) begin
                    if (p_left == P_W'(1)) begin
                        wrap   = 1'b1;
                        a_nxt  = a_cfg;
                        p_nxt  = p_cfg;
                        st_nxt = st_start;
                    end else begin
                        a_nxt = a_left - A_W'(1);
                        p_nxt = p_left - P_W'(1);
                        if (a_left == A_W'(1)) begin
                            st_nxt = FB_MAIN;
                        end
                    end
                end
            end
            FB_MAIN: begin
                if (pre_tick) begin
                    if (p_left == P_W'(1)) begin
                        wrap   = 1'b1;
                        a_nxt  = a_cfg;
                        p_nxt  = p_cfg;
                        st_nxt = st_start;
                    end else begin
                        p_nxt = p_left - P_W'(1);
                    end
                end
            end
            default: st_nxt = FB_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= FB_LOAD;
            a_left <= '0;
            p_left <= '0;
        end else begin
            st     <= st_nxt;
            a_left <= a_nxt;
            p_left <= p_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_pulse <= 1'b0;
        end else begin
            fb_pulse <= wrap;
        end
    end

    always_comb begin
        mod_ctl = (st == FB_SWALLOW);
    end

endmodule

// File: rtl/ref_div.sv
module ref_div
    import synth_div_pkg::*;
#(
    parameter int R_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_tick,
    input  logic [R_W-1:0] r_ratio,
    output logic           ref_pulse
);

    rf_state_t      st, st_nxt;
    logic [R_W-1:0] r_left, r_nxt;
    logic           wrap;

    always_comb begin
        st_nxt = st;
        r_nxt  = r_left;
        wrap   = 1'b0;
        unique case (st)
            RF_LOAD: begin
                r_nxt  = r_ratio;
                st_nxt = RF_COUNT;
            end
            RF_COUNT: begin
                if (ref_tick) begin
                    if (r_left == R_W'(1)) begin
                        wrap  = 1'b1;
                        r_nxt = r_ratio;
                    end else begin
                        r_nxt = r_left - R_W'(1);
                    end
                end
            end
            default: st_nxt = RF_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= RF_LOAD;
            r_left <= '0;
        end else begin
            st     <= st_nxt;
            r_left <= r_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_pulse <= 1'b0;
        end else begin
            ref_pulse <= wrap;
        end
    end

endmodule

// File: rtl/synth_div_pair.sv
module synth_div_pair #(
    parameter int A_W    = 4,
    parameter int P_W    = 10,
    parameter int R_W    = 11,
    parameter int M1_RST = 10519,
    parameter int M2_RST = 4269,
    parameter int R1_RST = 492,
    parameter int R2_RST = 492
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [A_W+P_W-1:0]  wr_data,
    input  logic                sel_bit,
    input  logic                sel_pin_drive,
    input  logic                sel_pin_val,
    input  logic                pre_tick,
    input  logic                ref_tick,
    output logic                mod_ctl,
    output logic                fb_pulse,
    output logic                ref_pulse
);

    localparam int M_W     = A_W + P_W;
    localparam int PRE_MOD = 1 << A_W;
    localparam int M_MIN   = PRE_MOD * PRE_MOD;
    localparam int R_MIN   = 2;

    logic [M_W-1:0] m_act;
    logic [R_W-1:0] r_act;

    div_ratio_bank #(
        .M_W(M_W), .R_W(R_W), .M_MIN(M_MIN), .R_MIN(R_MIN),
        .M1_RST(M1_RST), .M2_RST(M2_RST), .R1_RST(R1_RST), .R2_RST(R2_RST)
    ) bank_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sel_bit(sel_bit), .sel_pin_drive(sel_pin_drive), .sel_pin_val(sel_pin_val),
        .m_act(m_act), .r_act(r_act)
    );

    fb_swallow_div #(.A_W(A_W), .P_W(P_W)) fb_i (
        .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick),
        .m_ratio(m_act), .mod_ctl(mod_ctl), .fb_pulse(fb_pulse)
    );

    ref_div #(.R_W(R_W)) rf_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .r_ratio(r_act), .ref_pulse(ref_pulse)
    );

endmodule

// File: rtl/synth_div_chk.sv
module synth_div_chk (
    input logic clk,
    input logic rst_n,
    input logic pre_tick,
    input logic ref_tick,
    input logic mod_ctl,
    input logic fb_pulse,
    input logic ref_pulse
);

    assert_fb_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

    assert_fb_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fb_pulse) |-> $past(pre_tick));

    assert_mod_fall_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_ctl) |-> $past(pre_tick));

    assert_ref_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);

    assert_ref_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_pulse) |-> $past(ref_tick));

endmodule

bind synth_div_pair synth_div_chk chk_i (
    .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick), .ref_tick(ref_tick),
    .mod_ctl(mod_ctl), .fb_pulse(fb_pulse), .ref_pulse(ref_pulse)
);

// File: tb/synth_div_pair_tb_top.sv
module synth_div_pair_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [13:0] wr_data = '0;
    logic        sel_bit = 1'b1;
    logic        sel_pin_drive = 1'b0;
    logic        sel_pin_val = 1'b0;
    logic        pre_tick = 1'b0;
    logic        ref_tick = 1'b0;
    logic        mod_ctl, fb_pulse, ref_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // bench-side measurement state
    int cyc = 0;
    int ps_cnt = 0, ps_len = 16;
    int sw_cnt = 0, pt_cnt = 0;
    int fb_last = 0, fb_gap = 0, fb_sw = 0, fb_pt = 0, fb_n = 0;
    int rf_last = 0, rf_gap = 0, rf_n = 0;
    int rf_ph = 0, ref_every = 1;

    // vector: {write value, expected gap, expected /17 cycles, expected strobes}
    localparam logic [41:0] FB_VEC [6] = '{
        {14'd16383, 14'd16383, 4'd15, 10'd1023},
        {14'd256,   14'd256,   4'd0,  10'd16},
        {14'd271,   14'd271,   4'd15, 10'd16},
        {14'd100,   14'd256,   4'd0,  10'd16},
        {14'd1000,  14'd1000,  4'd8,  10'd62},
        {14'd4096,  14'd4096,  4'd0,  10'd256}
    };

    always #10 clk = ~clk;

    synth_div_pair dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sel_bit(sel_bit), .sel_pin_drive(sel_pin_drive), .sel_pin_val(sel_pin_val),
        .pre_tick(pre_tick), .ref_tick(ref_tick),
        .mod_ctl(mod_ctl), .fb_pulse(fb_pulse), .ref_pulse(ref_pulse)
    );

    // 16/17 prescaler model, reference strobe source and pulse monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            pre_tick = 1'b0;
            ref_tick = 1'b0;
            ps_cnt = 0;
            rf_ph = 0;
        end else begin
            cyc++;
            if (fb_pulse) begin
                fb_gap = cyc - fb_last;
                fb_last = cyc;
                fb_sw = sw_cnt;
                fb_pt = pt_cnt;
                sw_cnt = 0;
                pt_cnt = 0;
                fb_n++;
            end
            if (ref_pulse) begin
                rf_gap = cyc - rf_last;
                rf_last = cyc;
                rf_n++;
            end
            if (ps_cnt == 0) begin
                ps_len = mod_ctl ? 17 : 16;
                if (mod_ctl) sw_cnt++;
            end
            ps_cnt++;
            if (ps_cnt == ps_len) begin
                pre_tick = 1'b1;
                pt_cnt++;
                ps_cnt = 0;
            end else begin
                pre_tick = 1'b0;
            end
            if (rf_ph >= ref_every - 1) begin
                ref_tick = 1'b1;
                rf_ph = 0;
            end else begin
                ref_tick = 1'b0;
                rf_ph++;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_fb();
        int c = fb_n;
        while (fb_n == c) @(negedge clk);
    endtask

    task automatic wait_rf();
        int c = rf_n;
        while (rf_n == c) @(negedge clk);
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [13:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet during reset
        repeat (4) @(negedge clk);
        chk("R1 fb_pulse in reset", int'(fb_pulse), 0);
        chk("R1 ref_pulse in reset", int'(ref_pulse), 0);
        chk("R1 mod_ctl in reset", int'(mod_ctl), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: default M1 = 10519 (P=657, A=7), R1 = 492
        wait_fb();
        wait_fb();
        chk("R9 R4 default M1 spacing", fb_gap, 10519);
        chk("R3 default M1 /17 cycles", fb_sw, 7);
        chk("R2 default M1 strobes", fb_pt, 657);
        wait_rf();
        wait_rf();
        chk("R9 R5 default R1 spacing", rf_gap, 492);

        // R8: select flips mid-period, switch waits for boundary
        wait_fb();
        repeat (100) @(negedge clk);
        sel_bit = 1'b0;
        wait_fb();
        chk("R8 period in progress keeps M1", fb_gap, 10519);
        wait_fb();
        chk("R6 R9 select 0 gives default M2", fb_gap, 4269);

        // table walk: M2 writes with set 2 active
        for (int i = 0; i < 6; i++) begin
            write_reg(2'd1, FB_VEC[i][41:28]);
            wait_fb();
            wait_fb();
            chk("R4 R10 vector spacing", fb_gap, int'(FB_VEC[i][27:14]));
            chk("R3 vector /17 cycles", fb_sw, int'(FB_VEC[i][13:10]));
            chk("R2 vector strobes", fb_pt, int'(FB_VEC[i][9:0]));
        end

        // R7: pin override
        write_reg(2'd0, 14'd300);
        sel_pin_drive = 1'b1;
        sel_pin_val = 1'b1;
        sel_bit = 1'b0;
        wait_fb();
        wait_fb();
        chk("R7 pin 1 overrides bit 0", fb_gap, 300);
        chk("R3 M1=300 /17 cycles", fb_sw, 12);
        sel_bit = 1'b1;
        wait_fb();
        chk("R7 bit toggle ignored", fb_gap, 300);
        sel_pin_val = 1'b0;
        wait_fb();
        wait_fb();
        chk("R7 pin 0 overrides bit 1", fb_gap, 4096);
        sel_pin_drive = 1'b0;
        sel_bit = 1'b0;

        // reference divider corners on R2
        write_reg(2'd3, 14'd2);
        wait_rf(); wait_rf(); wait_rf();
        chk("R5 R=2 spacing", rf_gap, 2);
        write_reg(2'd3, 14'd2047);
        wait_rf(); wait_rf(); wait_rf();
        chk("R5 R=2047 spacing", rf_gap, 2047);
        write_reg(2'd3, 14'd1);
        wait_rf(); wait_rf(); wait_rf();
        chk("R10 R=1 clamped to 2", rf_gap, 2);
        write_reg(2'd3, 14'd2055);
        wait_rf(); wait_rf(); wait_rf();
        chk("R10 R keeps low 11 bits", rf_gap, 7);
        write_reg(2'd3, 14'd5);
        ref_every = 3;
        wait_rf(); wait_rf(); wait_rf();
        chk("R5 R=5 sparse strobes", rf_gap, 15);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule